// File: doc/BRIEF.md
# Gated Frequency Meter

The block estimates the frequency of a periodic digital signal. It counts the rising edges of that signal inside a gate window of fixed length, timed from the system clock. When a window ends, the edge total is captured into a result register and a one-cycle valid strobe is raised. A fresh window starts on the very next cycle, so windows follow each other with no gap.

Two window lengths are available and are chosen with a select input. Frequency in hertz is the result multiplied by the clock frequency and divided by the window length in clock cycles. One count therefore stands for one edge per gate time. With a 10 ms gate, 540 counts mean 54 kHz and each count is worth 100 Hz. With a 100 ms gate, the same 54 kHz signal gives about 5400 counts and each count is worth 10 Hz.

The measured signal is asynchronous to the system clock. It passes through a synchronizer before its edges are detected. The counter saturates rather than wrapping around, and it flags a saturated result.

Top module: `gated_freq_meter`

## Requirements
- R1: While reset is held and on the first cycle after it is released, result is 0, result_ovf is 0 and result_valid is 0.
- R2: Each rising edge of sig_in is counted exactly once. The edge is counted after a synchronizer of SYNC_STAGES flip-flops, followed by an edge detector in the clock domain. An input held at a constant level adds no counts.
- R3: With the window set to short (gate_sel=0), result_valid pulses every SHORT_GATE_CYC clock cycles. With the window set to long (gate_sel=1), it pulses every LONG_GATE_CYC cycles.
- R4: result holds the number of sig_in rising edges counted in the window that has just closed. For a steady input of period P cycles, where P divides the window length, the result is the window length divided by P.
- R5: The same input measured with both windows gives counts in the ratio LONG_GATE_CYC to SHORT_GATE_CYC. The resolution is one count per gate time.
- R6: result_valid is high for exactly one cycle per window. result and result_ovf change only together with that strobe and stay stable between strobes.
- R7: The edge counter is cleared at every window boundary, so no count carries over into the next window.
- R8: The count saturates at 2^CNT_W-1. If an edge arrives while the count is already at that value, result_ovf is 1 with that result. result_ovf returns to 0 with the next result that did not lose an edge.
- R9: The first window after reset is short. A change on gate_sel takes effect only from the next window boundary; the window already running keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the gate timing is derived from it |
| rst | input | 1 | Synchronous reset, active high |
| gate_sel | input | 1 | Window select: 0 chooses the short window, 1 chooses the long window |
| sig_in | input | 1 | Asynchronous signal whose edges are counted |
| result | output | CNT_W | Edge count of the window that last closed |
| result_ovf | output | 1 | The last result saturated and lost at least one edge |
| result_valid | output | 1 | One-cycle strobe when a new result has been captured |

## Verification
The hardest case to reach is the window-select handover. The select must change while a short window is running, and the bench must then see one more short window before the long one appears. The stimulus reaches it by changing gate_sel on the cycle right after a strobe, then measuring the spacing of the next two strobes.

Saturation is the other hard case. The bench reaches it by driving an edge every third cycle into a long window whose edge total exceeds the counter range. It then switches back to a slower input and checks that the overflow flag clears.

Any window in which the input pattern changed is thrown away. Only whole windows are compared against exact counts.

// File: rtl/gated_freq_meter_pkg.sv
package gated_freq_meter_pkg;
   typedef enum logic {
      GATE_SHORT = 1'b0,
      GATE_LONG  = 1'b1
   } gate_len_e;
endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= 1'b0;
               else     chain[0] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[s] <= 1'b0;
               else     chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer
   import gated_freq_meter_pkg::*;
#(
   parameter int SHORT_CYC = 10000,
   parameter int LONG_CYC  = 100000
) (
   input  logic clk,
   input  logic rst,
   input  logic sel,
   output logic win_end
);
   localparam int TW = $clog2(LONG_CYC);
   localparam logic [TW-1:0] SHORT_LAST = TW'(SHORT_CYC - 1);
   localparam logic [TW-1:0] LONG_LAST  = TW'(LONG_CYC - 1);

   gate_len_e     len_q;
   logic [TW-1:0] tick_q;
   logic [TW-1:0] last_tick;

   assign last_tick = (len_q == GATE_LONG) ? LONG_LAST : SHORT_LAST;
   assign win_end   = (tick_q == last_tick);

   always_ff @(posedge clk) begin
      if (rst) begin
         tick_q <= '0;
         len_q  <= GATE_SHORT;
      end else if (win_end) begin
         tick_q <= '0;
         len_q  <= gate_len_e'(sel);
      end else begin
         tick_q <= tick_q + 1'b1;
      end
   end
endmodule

// File: rtl/fm_sat_counter.sv
module fm_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   input  logic         clear,
   output logic [W-1:0] next_cnt,
   output logic         next_lost
);
   localparam logic [W-1:0] TOP = '1;

   logic [W-1:0] cnt_q;
   logic         lost_q;
   logic         at_top;

   assign at_top    = (cnt_q == TOP);
   assign next_cnt  = at_top ? cnt_q : cnt_q + W'(inc);
   assign next_lost = lost_q | (at_top & inc);

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         cnt_q  <= '0;
         lost_q <= 1'b0;
      end else begin
         cnt_q  <= next_cnt;
         lost_q <= next_lost;
      end
   end
endmodule

// File: rtl/gated_freq_meter.sv
module gated_freq_meter #(
   parameter int SHORT_GATE_CYC = 10000,
   parameter int LONG_GATE_CYC  = 100000,
   parameter int CNT_W          = 16,
   parameter int SYNC_STAGES    = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             gate_sel,
   input  logic             sig_in,
   output logic [CNT_W-1:0] result,
   output logic             result_ovf,
   output logic             result_valid
);
   generate
      if (SHORT_GATE_CYC < 2) begin : g_bad_short
         $error("SHORT_GATE_CYC must be at least 2");
      end
      if (LONG_GATE_CYC < SHORT_GATE_CYC) begin : g_bad_long
         $error("LONG_GATE_CYC must not be below SHORT_GATE_CYC");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_width
         $error("CNT_W must be at least 1");
      end
   endgenerate

   logic             edge_pulse;
   logic             win_end;
   logic [CNT_W-1:0] cnt_next;
   logic             lost_next;

   fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (sig_in),
      .rise     (edge_pulse)
   );

   fm_gate_timer #(.SHORT_CYC(SHORT_GATE_CYC), .LONG_CYC(LONG_GATE_CYC)) u_gate (
      .clk     (clk),
      .rst     (rst),
      .sel     (gate_sel),
      .win_end (win_end)
   );

   fm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst       (rst),
      .inc       (edge_pulse),
      .clear     (win_end),
      .next_cnt  (cnt_next),
      .next_lost (lost_next)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result       <= '0;
         result_ovf   <= 1'b0;
         result_valid <= 1'b0;
      end else begin
         result_valid <= win_end;
         if (win_end) begin
            result     <= cnt_next;
            result_ovf <= lost_next;
         end
      end
   end
endmodule

// File: rtl/gated_freq_meter_chk.sv
module gated_freq_meter_chk #(
   parameter int SHORT_GATE_CYC = 10000,
   parameter int LONG_GATE_CYC  = 100000,
   parameter int CNT_W          = 16
) (
   input logic             clk,
   input logic             rst,
   input logic [CNT_W-1:0] result,
   input logic             result_ovf,
   input logic             result_valid
);
   int unsigned since_q;

   always_ff @(posedge clk) begin
      if (rst)               since_q <= 0;
      else if (result_valid) since_q <= 1;
      else                   since_q <= since_q + 1;
   end

   assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
      result_valid |=> !result_valid);

   assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !result_valid |-> ($stable(result) && $stable(result_ovf)));

   assert_window_len_R3: assert property (@(posedge clk) disable iff (rst)
      result_valid |-> (since_q == SHORT_GATE_CYC || since_q == LONG_GATE_CYC));

   assert_no_early_strobe_R3: assert property (@(posedge clk) disable iff (rst)
      (since_q < SHORT_GATE_CYC) |-> !result_valid);

   assert_ovf_saturated_R8: assert property (@(posedge clk) disable iff (rst)
      result_ovf |-> (result == {CNT_W{1'b1}}));
endmodule

bind gated_freq_meter gated_freq_meter_chk #(
   .SHORT_GATE_CYC (SHORT_GATE_CYC),
   .LONG_GATE_CYC  (LONG_GATE_CYC),
   .CNT_W          (CNT_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .result       (result),
   .result_ovf   (result_ovf),
   .result_valid (result_valid)
);

// File: tb/gated_freq_meter_bench.sv
module gated_freq_meter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int SHORT_C    = 200;
   localparam int LONG_C     = 2000;
   localparam int CW         = 9;
   localparam int WATCHDOG   = 100000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          gate_sel = 1'b0;
   logic          sig_in = 1'b0;
   logic [CW-1:0] result;
   logic          result_ovf;
   logic          result_valid;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int last_strobe = 0;
   int gap = 0;
   bit gen_on = 1'b0;
   int gen_per = 4;
   int gen_hi  = 2;
   int gen_ph  = 0;
   int short_cnt = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gated_freq_meter #(
      .SHORT_GATE_CYC (SHORT_C),
      .LONG_GATE_CYC  (LONG_C),
      .CNT_W          (CW),
      .SYNC_STAGES    (2)
   ) u_gated_freq_meter (
      .clk          (clk),
      .rst          (rst),
      .gate_sel     (gate_sel),
      .sig_in       (sig_in),
      .result       (result),
      .result_ovf   (result_ovf),
      .result_valid (result_valid)
   );

   initial forever begin
      @(posedge clk);
      cyc = cyc + 1;
   end

   initial forever begin
      @(negedge clk);
      if (gen_on) begin
         sig_in = (gen_ph < gen_hi);
         gen_ph = (gen_ph + 1 == gen_per) ? 0 : gen_ph + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_strobe();
      do @(negedge clk); while (!result_valid);
      gap = cyc - last_strobe;
      last_strobe = cyc;
   endtask

   task automatic set_gen(input bit on, input int per, input int hi, input logic lvl);
      gen_on  = on;
      gen_per = per;
      gen_hi  = hi;
      gen_ph  = 0;
      if (!on) sig_in = lvl;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 result in reset", int'(result), 0);
      check("R1 valid in reset", int'(result_valid), 0);
      rst = 1'b0;
      last_strobe = cyc;
      @(negedge clk);
      check("R1 ovf after reset", int'(result_ovf), 0);
      check("R1 valid after reset", int'(result_valid), 0);
   endtask

   task automatic t_idle();
      wait_strobe();
      check("R9 first window short", gap, SHORT_C);
      check("R2 idle low count", int'(result), 0);
      @(negedge clk);
      check("R6 strobe one cycle", int'(result_valid), 0);
   endtask

   task automatic t_short();
      set_gen(1'b1, 4, 2, 1'b0);
      wait_strobe();
      wait_strobe();
      check("R4 short count P4", int'(result), SHORT_C / 4);
      check("R3 short spacing", gap, SHORT_C);
      short_cnt = int'(result);
      wait_strobe();
      check("R7 next window no carry", int'(result), SHORT_C / 4);
   endtask

   task automatic t_switch();
      gate_sel = 1'b1;
      wait_strobe();
      check("R9 running window keeps length", gap, SHORT_C);
      check("R9 running window count", int'(result), SHORT_C / 4);
      wait_strobe();
      check("R3 long spacing", gap, LONG_C);
      check("R4 long count P4", int'(result), LONG_C / 4);
      check("R5 long/short ratio", int'(result), short_cnt * (LONG_C / SHORT_C));
      check("R8 no ovf when unsaturated", int'(result_ovf), 0);
   endtask

   task automatic t_sat();
      set_gen(1'b1, 3, 1, 1'b0);
      wait_strobe();
      wait_strobe();
      check("R8 saturated value", int'(result), (1 << CW) - 1);
      check("R8 ovf set", int'(result_ovf), 1);
      set_gen(1'b1, 4, 2, 1'b0);
      wait_strobe();
      wait_strobe();
      check("R8 ovf cleared", int'(result_ovf), 0);
      check("R8 count after recovery", int'(result), LONG_C / 4);
   endtask

   task automatic t_stop();
      set_gen(1'b0, 4, 2, 1'b1);
      gate_sel = 1'b0;
      wait_strobe();
      check("R9 long window finishes", gap, LONG_C);
      wait_strobe();
      check("R2 constant high no counts", int'(result), 0);
      check("R3 back to short spacing", gap, SHORT_C);
      set_gen(1'b0, 4, 2, 1'b0);
      wait_strobe();
      wait_strobe();
      check("R7 stopped input count", int'(result), 0);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_short();
      t_switch();
      t_sat();
      t_stop();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule